// File: doc/BRIEF.md
# Multi-Bit Trie Longest-Prefix-Match Engine

This block resolves a destination address to a next hop by walking a fixed-stride trie held in on-chip node memory. Starting from the root node, each memory read consumes the next `STRIDE` bits of the address, most significant first. Those bits select one child pointer of the current node, and the walk follows it to the next level. As it goes, the engine keeps the next hop of the deepest node that carries a prefix. The walk stops when the selected pointer is null or when the node at the last level has been read. The engine then reports that next hop, or a miss.

A host loads node words through a simple write port while the engine is idle. Prefixes whose length is not a multiple of the stride must be expanded by the loader into several prefixes of the next multiple. The controller has three states:

- `ST_IDLE`: ready for a request, and host writes are taken.
- `ST_WALK`: one node word is examined per cycle.
- `ST_DONE`: the one-cycle response.

Its transitions are:

- IDLE→WALK on an accepted request.
- WALK→WALK when a non-null child is followed.
- WALK→DONE on a null child or at the last level.
- DONE→IDLE unconditionally.

Top module: `trie_lpm_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A node word is laid out as follows: bit 48 is prefix-valid, bits 47:40 are the next hop, and child d sits in bits [d*10 +: 10] for d = 0..3. The address is consumed from bit 31 downward, two bits per level, and the 2-bit digit value d selects child d.
- R3: On a hit, `rsp_hit` is 1 and `rsp_next_hop` is the next hop of the deepest prefix-valid node visited along the address path.
- R4: A selected child pointer of 0 is null and ends the walk at the current node.
- R5: After the node at depth 16 (32/2) is read, the walk ends whatever its child pointers hold, so at most 17 nodes are read per lookup.
- R6: If no visited node is prefix-valid, `rsp_hit` is 0 and `rsp_next_hop` is 0.
- R7: A prefix-valid root (node index 0) acts as a default route for every address.
- R8: A request is taken only when `req_valid` and `req_ready` are both 1. While a lookup is in progress `req_ready` is 0, and requests raised then produce no response.
- R9: `rsp_valid` is a single-cycle pulse. It rises exactly N cycles after the accepting edge, where N is the number of nodes read, and `req_ready` returns to 1 the cycle after.
- R10: A host write takes effect only when `req_ready` is 1. A write presented during a lookup is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Engine idle; request and host write accepted |
| req_addr | input | 32 | Destination address to resolve |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | A prefix matched |
| rsp_next_hop | output | 8 | Next hop of the longest match, 0 on a miss |
| wr_en | input | 1 | Host node write enable |
| wr_idx | input | 10 | Node index to write |
| wr_data | input | 49 | Node word to write |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- **Path that passes a prefix node and ends deeper on a null pointer.** An engine that returned only the last node read, instead of the deepest prefix holder, would report a miss.
- **Full-depth chain whose last node has non-null pointers.** An engine that ignored the level limit would chase those pointers and return the wrong hop or hang.
- **Writes and a second request raised mid-walk.** A design that accepted either would corrupt the table or emit an extra response.
- **Response latency against the node count.** This catches an off-by-one in the memory-latency handling.
- **Misses with and without a default root.** These check the zero next hop on a miss.

// File: rtl/trie_pkg.sv
package trie_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } walk_state_e;

endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem #(
    parameter int DATA_W = 49,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              re,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[wr_idx] <= wr_data;
        end
        if (re) begin
            rd_data <= store[rd_idx];
        end
    end
endmodule

// File: rtl/trie_node_unpack.sv
module trie_node_unpack #(
    parameter int IDX_W  = 10,
    parameter int NH_W   = 8,
    parameter int STRIDE = 2,
    localparam int FANOUT = 1 << STRIDE,
    localparam int NODE_W = 1 + NH_W + FANOUT * IDX_W
) (
    input  logic [NODE_W-1:0] word,
    input  logic [STRIDE-1:0] digit,
    output logic              pfx_valid,
    output logic [NH_W-1:0]   next_hop,
    output logic [IDX_W-1:0]  sel_child
);
    logic [FANOUT-1:0][IDX_W-1:0] kids;

    assign pfx_valid = word[NODE_W-1];
    assign next_hop  = word[NODE_W-2 -: NH_W];

    for (genvar d = 0; d < FANOUT; d++) begin : g_kid
        assign kids[d] = word[d*IDX_W +: IDX_W];
    end

    assign sel_child = kids[digit];
endmodule

// File: rtl/trie_walk_ctrl.sv
module trie_walk_ctrl
    import trie_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 2,
    parameter int IDX_W  = 10,
    parameter int NH_W   = 8,
    localparam int LEVELS = ADDR_W / STRIDE,
    localparam int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              node_pfx,
    input  logic [NH_W-1:0]   node_nh,
    input  logic [IDX_W-1:0]  sel_child,
    output logic [STRIDE-1:0] digit,
    output logic              req_ready,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NH_W-1:0]   rsp_next_hop,
    output logic [LVL_W-1:0]  level
);
    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0] key_q;
    logic [LVL_W-1:0]  level_q;
    logic              best_hit_q;
    logic [NH_W-1:0]   best_nh_q;

    logic accept;
    logic at_end;
    logic walk_stop;
    logic in_walk;

    assign digit     = key_q[ADDR_W-1 -: STRIDE];
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign in_walk   = (state_q == ST_WALK);
    assign at_end    = (level_q == LVL_W'(LEVELS));
    assign walk_stop = at_end || (sel_child == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_WALK;
            ST_WALK: if (walk_stop) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q      <= '0;
            level_q    <= '0;
            best_hit_q <= 1'b0;
            best_nh_q  <= '0;
        end else if (accept) begin
            key_q      <= req_addr;
            level_q    <= '0;
            best_hit_q <= 1'b0;
            best_nh_q  <= '0;
        end else if (in_walk) begin
            if (node_pfx) begin
                best_hit_q <= 1'b1;
                best_nh_q  <= node_nh;
            end
            if (!walk_stop) begin
                key_q   <= key_q << STRIDE;
                level_q <= level_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        rd_en        = 1'b0;
        rd_idx       = '0;
        rsp_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                rd_en     = req_valid;
                rd_idx    = '0;
            end
            ST_WALK: begin
                rd_en  = !walk_stop;
                rd_idx = sel_child;
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
            end
            default: begin
                rd_en = 1'b0;
            end
        endcase
        rsp_hit      = best_hit_q;
        rsp_next_hop = best_nh_q;
        level        = level_q;
    end
endmodule

// File: rtl/trie_lpm_engine.sv
module trie_lpm_engine #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 2,
    parameter int IDX_W  = 10,
    parameter int NH_W   = 8,
    localparam int FANOUT = 1 << STRIDE,
    localparam int NODE_W = 1 + NH_W + FANOUT * IDX_W,
    localparam int LEVELS = ADDR_W / STRIDE,
    localparam int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NH_W-1:0]   rsp_next_hop,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [NODE_W-1:0] wr_data
);
    logic              mem_we;
    logic              rd_en;
    logic [IDX_W-1:0]  rd_idx;
    logic [NODE_W-1:0] node_word;
    logic [STRIDE-1:0] digit;
    logic              node_pfx;
    logic [NH_W-1:0]   node_nh;
    logic [IDX_W-1:0]  sel_child;
    logic [LVL_W-1:0]  walk_level;

    // host updates only land while no walk is in flight
    assign mem_we = wr_en && req_ready;

    trie_node_mem #(.DATA_W(NODE_W), .IDX_W(IDX_W)) u_mem (
        .clk    (clk),
        .we     (mem_we),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .re     (rd_en),
        .rd_idx (rd_idx),
        .rd_data(node_word)
    );

    trie_node_unpack #(.IDX_W(IDX_W), .NH_W(NH_W), .STRIDE(STRIDE)) u_unpack (
        .word     (node_word),
        .digit    (digit),
        .pfx_valid(node_pfx),
        .next_hop (node_nh),
        .sel_child(sel_child)
    );

    trie_walk_ctrl #(
        .ADDR_W(ADDR_W), .STRIDE(STRIDE), .IDX_W(IDX_W), .NH_W(NH_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .node_pfx    (node_pfx),
        .node_nh     (node_nh),
        .sel_child   (sel_child),
        .digit       (digit),
        .req_ready   (req_ready),
        .rd_en       (rd_en),
        .rd_idx      (rd_idx),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_next_hop(rsp_next_hop),
        .level       (walk_level)
    );
endmodule

// File: rtl/trie_lpm_checks.sv
module trie_lpm_checks #(
    parameter int NH_W   = 8,
    parameter int LVL_W  = 5,
    parameter int LEVELS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [NH_W-1:0]  rsp_next_hop,
    input logic             mem_we,
    input logic [LVL_W-1:0] walk_level
);
    assert_accept_goes_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_then_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    assert_busy_no_rsp_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_miss_zero_hop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_next_hop == '0));

    assert_depth_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        walk_level <= LVL_W'(LEVELS));

    assert_write_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> req_ready);
endmodule

bind trie_lpm_engine trie_lpm_checks #(
    .NH_W(NH_W), .LVL_W(LVL_W), .LEVELS(LEVELS)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_next_hop(rsp_next_hop),
    .mem_we      (mem_we),
    .walk_level  (walk_level)
);

// File: tb/trie_lpm_engine_test.sv
`timescale 1ns/1ps
module trie_lpm_engine_test;
    localparam int NODE_W = 49;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_addr = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [7:0]        rsp_next_hop;
    logic              wr_en = 1'b0;
    logic [9:0]        wr_idx = '0;
    logic [NODE_W-1:0] wr_data = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        logic       hit;
        logic [7:0] nh;
        int         lat;
        int         t0;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    trie_lpm_engine uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_next_hop(rsp_next_hop), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NODE_W-1:0] mk_node(input logic pv, input logic [7:0] nh,
            input logic [9:0] c0, input logic [9:0] c1, input logic [9:0] c2, input logic [9:0] c3);
        return {pv, nh, c3, c2, c1, c0};
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp_v);
        end
    endtask

    task automatic host_write(input logic [9:0] idx, input logic [NODE_W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic lookup(input logic [31:0] key, input logic hit, input logic [7:0] nh,
                          input int lat, input string tag, input bit wait_done);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = key;
        @(posedge clk);
        #1;
        e.hit = hit; e.nh = nh; e.lat = lat; e.t0 = cyc; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (wait_done) drain();
    endtask

    // monitor / scoreboard
    logic prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rsp) begin
                check(!rsp_valid && req_ready, "R9 pulse ends and ready returns",
                      {rsp_valid, req_ready}, 2'b01);
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_hit == e.hit, {e.tag, " hit"}, rsp_hit, e.hit);
                    check(rsp_next_hop == e.nh, {e.tag, " next hop"}, rsp_next_hop, e.nh);
                    check((cyc - e.t0) == e.lat, "R9 latency", cyc - e.t0, e.lat);
                end
            end
            prev_rsp <= rsp_valid;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset state",
              {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 after release",
              {req_ready, rsp_valid}, 2'b10);

        // table: 111*->10, 10*->22, 1010*->33, 10101->44 (expanded to stride 2)
        host_write(10'd0, mk_node(1'b0, 8'h00, 10'd0, 10'd0, 10'd1, 10'd5));
        host_write(10'd1, mk_node(1'b1, 8'h22, 10'd0, 10'd0, 10'd2, 10'd0));
        host_write(10'd2, mk_node(1'b1, 8'h33, 10'd0, 10'd0, 10'd3, 10'd4));
        host_write(10'd3, mk_node(1'b1, 8'h44, 10'd0, 10'd0, 10'd0, 10'd0));
        host_write(10'd4, mk_node(1'b1, 8'h44, 10'd0, 10'd0, 10'd0, 10'd0));
        host_write(10'd5, mk_node(1'b0, 8'h00, 10'd0, 10'd0, 10'd6, 10'd7));
        host_write(10'd6, mk_node(1'b1, 8'h10, 10'd0, 10'd0, 10'd0, 10'd0));
        host_write(10'd7, mk_node(1'b1, 8'h10, 10'd0, 10'd0, 10'd0, 10'd0));

        lookup(32'hB800_0000, 1'b1, 8'h22, 2, "R3 key 10111 gives 10*", 1'b1);
        lookup(32'hA800_0000, 1'b1, 8'h44, 4, "R2 key 101010", 1'b1);
        lookup(32'hAC00_0000, 1'b1, 8'h44, 4, "R2 key 101011", 1'b1);
        lookup(32'hA000_0000, 1'b1, 8'h33, 3, "R3 key 101000", 1'b1);
        lookup(32'hE000_0000, 1'b1, 8'h10, 3, "R3 key 1110", 1'b1);
        lookup(32'h9000_0000, 1'b1, 8'h22, 2, "R4 null child at 10*", 1'b1);
        lookup(32'h4000_0000, 1'b0, 8'h00, 1, "R6 miss at root", 1'b1);

        // chain of 16 levels under root digit 01, all further digits 11
        host_write(10'd0, mk_node(1'b0, 8'h00, 10'd0, 10'd20, 10'd0, 10'd0));
        for (int d = 1; d <= 15; d++) begin
            host_write(10'(19 + d), mk_node(d == 8, (d == 8) ? 8'h55 : 8'h00,
                       10'd0, 10'd0, 10'd0, 10'(20 + d)));
        end
        host_write(10'd35, mk_node(1'b1, 8'h99, 10'd1, 10'd1, 10'd1, 10'd1));

        lookup(32'h7FFF_FFFF, 1'b1, 8'h99, 17, "R5 full depth stop", 1'b1);
        lookup(32'h7FFF_0000, 1'b1, 8'h55, 9, "R4 null below depth 8", 1'b1);
        lookup(32'h7FFF_FFFE, 1'b1, 8'h55, 16, "R3 deepest prefix kept", 1'b1);
        lookup(32'h0000_0000, 1'b0, 8'h00, 1, "R6 miss no default", 1'b1);

        // write and request while busy must be dropped
        lookup(32'h7FFF_FFFF, 1'b1, 8'h99, 17, "R10 lookup during busy write", 1'b0);
        @(negedge clk);
        check(req_ready == 1'b0, "R8 not ready while walking", req_ready, 0);
        wr_en = 1'b1; wr_idx = 10'd35; wr_data = mk_node(1'b1, 8'hEE, 10'd0, 10'd0, 10'd0, 10'd0);
        req_valid = 1'b1; req_addr = 32'h0000_0000;
        repeat (2) @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        drain();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && req_ready == 1'b1, "R8 no extra response",
              exp_q.size(), 0);
        lookup(32'h7FFF_FFFF, 1'b1, 8'h99, 17, "R10 busy write dropped", 1'b1);

        host_write(10'd35, mk_node(1'b1, 8'hEE, 10'd0, 10'd0, 10'd0, 10'd0));
        lookup(32'h7FFF_FFFF, 1'b1, 8'hEE, 17, "R10 idle write taken", 1'b1);

        // default route at root
        host_write(10'd0, mk_node(1'b1, 8'h11, 10'd0, 10'd20, 10'd0, 10'd0));
        lookup(32'h0000_0000, 1'b1, 8'h11, 1, "R7 root default", 1'b1);
        lookup(32'hC000_0000, 1'b1, 8'h11, 1, "R7 root default other digit", 1'b1);
        lookup(32'h7FFF_0000, 1'b1, 8'h55, 9, "R3 deeper beats default", 1'b1);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule